// File: doc/BRIEF.md
# Pauli Frame Tracker and Arbiter

This block sits between an instruction source and the physical execution stage of a qubit controller. It receives physical qubit operations and keeps two classical bits per data qubit, x and z. These bits record Pauli errors and Pauli gates that were never applied to the hardware. Pauli gates on data qubits are folded into these bits and go no further. Clifford gates are issued and also transform the bits. Non-Clifford gates first cause one physical correction gate built from the pending bits and are then issued. Operations that name an ancilla qubit pass through untouched.

Measurement results come back on a separate port. Each result is corrected with the x bit of its qubit and presented on a logical-measurement output. The record of that qubit then starts again from zero. All three streams (operations in, operations out, results in and out) use valid/ready handshakes, and each output holds a single registered slot.

Top module: `pauli_frame_arbiter`

## Requirements
- R1: After reset no output is valid, both input ready signals are high, and every record is zero, so a result returned on any qubit comes out unchanged.
- R2: An operation with the ancilla flag set is issued downstream with opcode, qubits and flag unchanged, whatever the opcode, and no record changes.
- R3: On a data qubit, opcode 1 (X) toggles x, opcode 3 (Z) toggles z and opcode 2 (Y) toggles both; nothing is issued downstream.
- R4: Opcode 4 (H) on a data qubit is issued and exchanges the qubit's x and z bits.
- R5: Opcode 5 (S) on a data qubit is issued and replaces z with z XOR x.
- R6: Opcode 6 (CNOT, first qubit is the target, second the control) is issued; the target's x takes x_target XOR x_control and the control's z takes z_control XOR z_target.
- R7: Opcodes 7 and 8 (T and its inverse) on a data qubit with a non-zero record first issue one correction on that qubit with the ancilla flag clear and second qubit 0: Y when both bits are set, X when only x, Z when only z; the record is then zero and the gate follows next. With a zero record only the gate is issued.
- R8: While a correction waits for its gate to be issued, the input ready signal stays low.
- R9: Opcode 9 (Z-basis measurement) is issued unchanged; a returned result bit is inverted exactly when the qubit's x bit is set (z has no effect) and the qubit's record is zero afterwards.
- R10: When a result and a gate update reach the same qubit in one cycle, the result is translated with the old record, the record is cleared first and the gate then acts on the cleared record.
- R11: Each output keeps its payload stable while valid and not ready; every accepted operation and result appears exactly once and in order.
- R12: Any other opcode on a data qubit is issued unchanged and leaves the records alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation taken this cycle |
| in_op | input | 4 | Operation opcode |
| in_qa | input | QW (4) | Target qubit |
| in_qb | input | QW (4) | Second qubit (control for CNOT) |
| in_anc | input | 1 | Operation acts on ancilla qubits |
| dn_valid | output | 1 | Downstream operation valid |
| dn_ready | input | 1 | Downstream stage takes the operation |
| dn_op | output | 4 | Issued opcode |
| dn_qa | output | QW (4) | Issued target qubit |
| dn_qb | output | QW (4) | Issued second qubit |
| dn_anc | output | 1 | Issued ancilla flag |
| mr_valid | input | 1 | Raw measurement result offered |
| mr_ready | output | 1 | Result taken this cycle |
| mr_qubit | input | QW (4) | Measured data qubit |
| mr_bit | input | 1 | Raw result bit |
| lm_valid | output | 1 | Translated result valid |
| lm_ready | input | 1 | Consumer takes the translated result |
| lm_qubit | output | QW (4) | Qubit of the translated result |
| lm_bit | output | 1 | Translated result bit |

## Verification
Result translation and gate tracking both write the record store, and they can hit the same qubit on the same clock edge. The bench provokes this by raising an X operation and a raw result for one qubit with a set x bit in the same cycle while both ready signals are high. It judges the order by the translated bit, which must use the old x, and by a later result on that qubit, which shows x set again only if the clear came before the toggle. A random-stall burst then mixes the two streams while the scoreboard checks ordering.

// File: rtl/pf_pkg.sv
package pf_pkg;

  localparam logic [3:0] OP_X   = 4'd1;
  localparam logic [3:0] OP_Y   = 4'd2;
  localparam logic [3:0] OP_Z   = 4'd3;
  localparam logic [3:0] OP_H   = 4'd4;
  localparam logic [3:0] OP_S   = 4'd5;
  localparam logic [3:0] OP_CX  = 4'd6;
  localparam logic [3:0] OP_T   = 4'd7;
  localparam logic [3:0] OP_TDG = 4'd8;
  localparam logic [3:0] OP_MZ  = 4'd9;

  typedef struct packed {
    logic x;
    logic z;
  } pf_rec_t;

  function automatic logic op_is_pauli(input logic [3:0] op);
    return (op == OP_X) || (op == OP_Y) || (op == OP_Z);
  endfunction

  function automatic logic op_is_clifford(input logic [3:0] op);
    return (op == OP_H) || (op == OP_S) || (op == OP_CX);
  endfunction

  function automatic logic op_is_nonclifford(input logic [3:0] op);
    return (op == OP_T) || (op == OP_TDG);
  endfunction

endpackage

// File: rtl/pf_record_file.sv
module pf_record_file
  import pf_pkg::*;
#(
  parameter int NQ = 16,
  parameter int QW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic [3:0]    upd_op,
  input  logic [QW-1:0] upd_qa,
  input  logic [QW-1:0] upd_qb,
  input  logic          clr_a_en,
  input  logic [QW-1:0] clr_a_q,
  input  logic          clr_b_en,
  input  logic [QW-1:0] clr_b_q,
  output pf_rec_t       rd_a,
  input  logic [QW-1:0] rd_r_q,
  output logic          rd_r_x
);

  logic [NQ-1:0] x_q, z_q;
  logic [NQ-1:0] xc, zc;
  logic [NQ-1:0] x_n, z_n;
  logic          wr_en;

  assign wr_en  = upd_en | clr_a_en | clr_b_en;
  assign rd_a   = '{x: x_q[upd_qa], z: z_q[upd_qa]};
  assign rd_r_x = x_q[rd_r_q];

  for (genvar i = 0; i < NQ; i++) begin : g_qubit
    logic clr_i, hit_a, hit_b;
    logic nx, nz;

    assign clr_i = (clr_a_en && (clr_a_q == QW'(i))) ||
                   (clr_b_en && (clr_b_q == QW'(i)));
    assign xc[i] = clr_i ? 1'b0 : x_q[i];
    assign zc[i] = clr_i ? 1'b0 : z_q[i];
    assign hit_a = upd_en && (upd_qa == QW'(i));
    assign hit_b = upd_en && (upd_op == OP_CX) && (upd_qb == QW'(i));

    always_comb begin
      nx = xc[i];
      nz = zc[i];
      if (hit_a) begin
        unique case (upd_op)
          OP_X:    nx = ~xc[i];
          OP_Z:    nz = ~zc[i];
          OP_Y:    begin nx = ~xc[i]; nz = ~zc[i]; end
          OP_H:    begin nx = zc[i];  nz = xc[i];  end
          OP_S:    nz = zc[i] ^ xc[i];
          OP_CX:   nx = xc[i] ^ xc[upd_qb];
          default: ;
        endcase
      end
      if (hit_b) nz = zc[i] ^ zc[upd_qa];
    end

    assign x_n[i] = nx;
    assign z_n[i] = nz;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      z_q <= '0;
    end else if (wr_en) begin
      x_q <= x_n;
      z_q <= z_n;
    end
  end

  // R3: an X update without a same-qubit clear flips x
  p_x_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_op == OP_X && !(clr_b_en && clr_b_q == upd_qa))
    |=> x_q[$past(upd_qa)] != $past(x_q[upd_qa]));

  // R4: H exchanges the two bits
  p_h_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_op == OP_H && !(clr_b_en && clr_b_q == upd_qa))
    |=> (x_q[$past(upd_qa)] == $past(z_q[upd_qa])) &&
        (z_q[$past(upd_qa)] == $past(x_q[upd_qa])));

  // R9: a translated result leaves its record at zero
  p_result_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_b_en && !(upd_en && (upd_qa == clr_b_q ||
                   (upd_op == OP_CX && upd_qb == clr_b_q))))
    |=> (x_q[$past(clr_b_q)] == 1'b0) && (z_q[$past(clr_b_q)] == 1'b0));

  // R10: clear before gate when both hit one qubit
  p_collide_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_op == OP_X && clr_b_en && clr_b_q == upd_qa)
    |=> x_q[$past(upd_qa)] == 1'b1);

endmodule

// File: rtl/pf_issue_ctrl.sv
module pf_issue_ctrl
  import pf_pkg::*;
#(
  parameter int QW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    in_op,
  input  logic [QW-1:0] in_qa,
  input  logic [QW-1:0] in_qb,
  input  logic          in_anc,
  input  pf_rec_t       rec_a,
  output logic          upd_en,
  output logic          corr_clr,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [3:0]    dn_op,
  output logic [QW-1:0] dn_qa,
  output logic [QW-1:0] dn_qb,
  output logic          dn_anc
);

  typedef enum logic {ST_IDLE, ST_HOLD} st_e;

  st_e           st_q, st_n;
  logic          dn_valid_q, dn_valid_n;
  logic [3:0]    dn_op_q;
  logic [QW-1:0] dn_qa_q, dn_qb_q;
  logic          dn_anc_q;
  logic [3:0]    hold_op_q;
  logic [QW-1:0] hold_qa_q, hold_qb_q;

  logic          acc, is_p, is_c, is_ng, need_corr;
  logic          ld, hold_ld;
  logic [3:0]    ld_op, corr_op;
  logic [QW-1:0] ld_qa, ld_qb;
  logic          ld_anc;

  assign in_ready  = (st_q == ST_IDLE) && (!dn_valid_q || dn_ready);
  assign acc       = in_valid && in_ready;
  assign is_p      = !in_anc && op_is_pauli(in_op);
  assign is_c      = !in_anc && op_is_clifford(in_op);
  assign is_ng     = !in_anc && op_is_nonclifford(in_op);
  assign need_corr = is_ng && (rec_a.x || rec_a.z);
  assign upd_en    = acc && (is_p || is_c);
  assign corr_clr  = acc && need_corr;

  always_comb begin
    if (rec_a.x && rec_a.z) corr_op = OP_Y;
    else if (rec_a.x)       corr_op = OP_X;
    else                    corr_op = OP_Z;
  end

  always_comb begin
    st_n       = st_q;
    dn_valid_n = dn_valid_q && !dn_ready;
    ld         = 1'b0;
    hold_ld    = 1'b0;
    ld_op      = in_op;
    ld_qa      = in_qa;
    ld_qb      = in_qb;
    ld_anc     = in_anc;
    if (st_q == ST_HOLD) begin
      if (dn_ready) begin
        ld         = 1'b1;
        dn_valid_n = 1'b1;
        ld_op      = hold_op_q;
        ld_qa      = hold_qa_q;
        ld_qb      = hold_qb_q;
        ld_anc     = 1'b0;
        st_n       = ST_IDLE;
      end
    end else if (acc && !is_p) begin
      ld         = 1'b1;
      dn_valid_n = 1'b1;
      if (need_corr) begin
        ld_op   = corr_op;
        ld_qb   = '0;
        ld_anc  = 1'b0;
        hold_ld = 1'b1;
        st_n    = ST_HOLD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      dn_valid_q <= 1'b0;
      dn_op_q    <= '0;
      dn_qa_q    <= '0;
      dn_qb_q    <= '0;
      dn_anc_q   <= 1'b0;
      hold_op_q  <= '0;
      hold_qa_q  <= '0;
      hold_qb_q  <= '0;
    end else begin
      st_q       <= st_n;
      dn_valid_q <= dn_valid_n;
      if (ld) begin
        dn_op_q  <= ld_op;
        dn_qa_q  <= ld_qa;
        dn_qb_q  <= ld_qb;
        dn_anc_q <= ld_anc;
      end
      if (hold_ld) begin
        hold_op_q <= in_op;
        hold_qa_q <= in_qa;
        hold_qb_q <= in_qb;
      end
    end
  end

  assign dn_valid = dn_valid_q;
  assign dn_op    = dn_op_q;
  assign dn_qa    = dn_qa_q;
  assign dn_qb    = dn_qb_q;
  assign dn_anc   = dn_anc_q;

  // R8: nothing enters while a correction is outstanding
  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD) |-> (!in_ready && dn_valid));

  // R7: the gate follows its correction directly
  p_corr_then_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD && dn_ready)
    |=> dn_valid && (dn_op == OP_T || dn_op == OP_TDG) && !dn_anc);

  // R11: a stalled downstream slot keeps its payload
  p_dn_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready)
    |=> dn_valid && $stable(dn_op) && $stable(dn_qa) &&
        $stable(dn_qb) && $stable(dn_anc));

  // R2: ancilla operations emerge as they came in
  p_anc_forward_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_anc)
    |=> dn_valid && dn_anc && dn_op == $past(in_op) && dn_qa == $past(in_qa));

endmodule

// File: rtl/pf_result_xlate.sv
module pf_result_xlate #(
  parameter int QW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mr_valid,
  output logic          mr_ready,
  input  logic [QW-1:0] mr_qubit,
  input  logic          mr_bit,
  input  logic          rec_x,
  output logic          clr_en,
  output logic [QW-1:0] clr_q,
  output logic          lm_valid,
  input  logic          lm_ready,
  output logic [QW-1:0] lm_qubit,
  output logic          lm_bit
);

  logic          lm_valid_q, lm_valid_n;
  logic [QW-1:0] lm_qubit_q;
  logic          lm_bit_q;
  logic          acc;

  assign mr_ready = !lm_valid_q || lm_ready;
  assign acc      = mr_valid && mr_ready;
  assign clr_en   = acc;
  assign clr_q    = mr_qubit;

  always_comb begin
    lm_valid_n = lm_valid_q && !lm_ready;
    if (acc) lm_valid_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lm_valid_q <= 1'b0;
      lm_qubit_q <= '0;
      lm_bit_q   <= 1'b0;
    end else begin
      lm_valid_q <= lm_valid_n;
      if (acc) begin
        lm_qubit_q <= mr_qubit;
        lm_bit_q   <= mr_bit ^ rec_x;
      end
    end
  end

  assign lm_valid = lm_valid_q;
  assign lm_qubit = lm_qubit_q;
  assign lm_bit   = lm_bit_q;

  // R11: a stalled result keeps its payload
  p_lm_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (lm_valid && !lm_ready) |=> lm_valid && $stable(lm_qubit) && $stable(lm_bit));

  // R9: an accepted result is presented on the next cycle for its qubit
  p_lm_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> lm_valid && lm_qubit == $past(mr_qubit));

endmodule

// File: rtl/pauli_frame_arbiter.sv
module pauli_frame_arbiter
  import pf_pkg::*;
#(
  parameter  int NQ = 16,
  localparam int QW = $clog2(NQ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    in_op,
  input  logic [QW-1:0] in_qa,
  input  logic [QW-1:0] in_qb,
  input  logic          in_anc,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [3:0]    dn_op,
  output logic [QW-1:0] dn_qa,
  output logic [QW-1:0] dn_qb,
  output logic          dn_anc,
  input  logic          mr_valid,
  output logic          mr_ready,
  input  logic [QW-1:0] mr_qubit,
  input  logic          mr_bit,
  output logic          lm_valid,
  input  logic          lm_ready,
  output logic [QW-1:0] lm_qubit,
  output logic          lm_bit
);

  pf_rec_t       rec_a;
  logic          rec_rx;
  logic          upd_en, corr_clr;
  logic          res_clr;
  logic [QW-1:0] res_clr_q;

  pf_record_file #(.NQ(NQ), .QW(QW)) u_records (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (upd_en),
    .upd_op   (in_op),
    .upd_qa   (in_qa),
    .upd_qb   (in_qb),
    .clr_a_en (corr_clr),
    .clr_a_q  (in_qa),
    .clr_b_en (res_clr),
    .clr_b_q  (res_clr_q),
    .rd_a     (rec_a),
    .rd_r_q   (mr_qubit),
    .rd_r_x   (rec_rx)
  );

  pf_issue_ctrl #(.QW(QW)) u_issue (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_op    (in_op),
    .in_qa    (in_qa),
    .in_qb    (in_qb),
    .in_anc   (in_anc),
    .rec_a    (rec_a),
    .upd_en   (upd_en),
    .corr_clr (corr_clr),
    .dn_valid (dn_valid),
    .dn_ready (dn_ready),
    .dn_op    (dn_op),
    .dn_qa    (dn_qa),
    .dn_qb    (dn_qb),
    .dn_anc   (dn_anc)
  );

  pf_result_xlate #(.QW(QW)) u_xlate (
    .clk      (clk),
    .rst_n    (rst_n),
    .mr_valid (mr_valid),
    .mr_ready (mr_ready),
    .mr_qubit (mr_qubit),
    .mr_bit   (mr_bit),
    .rec_x    (rec_rx),
    .clr_en   (res_clr),
    .clr_q    (res_clr_q),
    .lm_valid (lm_valid),
    .lm_ready (lm_ready),
    .lm_qubit (lm_qubit),
    .lm_bit   (lm_bit)
  );

endmodule

// File: tb/pauli_frame_arbiter_bench.sv
module pauli_frame_arbiter_bench;
  import pf_pkg::*;

  localparam int NQ = 16;
  localparam int QW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_ready, in_anc;
  logic [3:0]    in_op;
  logic [QW-1:0] in_qa, in_qb;
  logic          dn_valid, dn_ready, dn_anc;
  logic [3:0]    dn_op;
  logic [QW-1:0] dn_qa, dn_qb;
  logic          mr_valid, mr_ready, mr_bit;
  logic [QW-1:0] mr_qubit;
  logic          lm_valid, lm_ready, lm_bit;
  logic [QW-1:0] lm_qubit;

  always #2.5 clk = ~clk;

  pauli_frame_arbiter #(.NQ(NQ)) u_pauli_frame_arbiter (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_qa(in_qa), .in_qb(in_qb), .in_anc(in_anc),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_op(dn_op),
    .dn_qa(dn_qa), .dn_qb(dn_qb), .dn_anc(dn_anc),
    .mr_valid(mr_valid), .mr_ready(mr_ready), .mr_qubit(mr_qubit), .mr_bit(mr_bit),
    .lm_valid(lm_valid), .lm_ready(lm_ready), .lm_qubit(lm_qubit), .lm_bit(lm_bit)
  );

  typedef struct {
    logic [3:0] op;
    int         qa;
    int         qb;
    logic       anc;
    string      tag;
  } dn_exp_t;

  typedef struct {
    int    q;
    logic  b;
    string tag;
  } lm_exp_t;

  dn_exp_t dn_q[$];
  lm_exp_t lm_q[$];
  bit      mx[NQ];
  bit      mz[NQ];
  int      n_checks = 0;
  int      n_fail   = 0;
  bit      stall_en = 1'b0;
  bit      dn_hold  = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // ready generators
  always @(negedge clk) begin
    lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    dn_ready = dn_hold ? 1'b0 : (stall_en ? lfsr[0] : 1'b1);
    lm_ready = stall_en ? lfsr[3] : 1'b1;
  end

  // downstream monitor
  initial forever begin
    @(negedge clk);
    #2;
    if (dn_valid && dn_ready) begin
      if (dn_q.size() == 0) begin
        check(1'b0, "R11", "unexpected downstream op", int'(dn_op), 0);
      end else begin
        dn_exp_t e;
        e = dn_q.pop_front();
        check(dn_op == e.op, e.tag, "dn_op", int'(dn_op), int'(e.op));
        check(dn_qa == QW'(e.qa) && dn_qb == QW'(e.qb), e.tag, "dn qubits",
              int'({dn_qa, dn_qb}), (e.qa << QW) | e.qb);
        check(dn_anc == e.anc, e.tag, "dn_anc", int'(dn_anc), int'(e.anc));
      end
    end
  end

  // result monitor
  initial forever begin
    @(negedge clk);
    #2;
    if (lm_valid && lm_ready) begin
      if (lm_q.size() == 0) begin
        check(1'b0, "R11", "unexpected result", int'(lm_bit), 0);
      end else begin
        lm_exp_t e;
        e = lm_q.pop_front();
        check(lm_qubit == QW'(e.q), e.tag, "lm_qubit", int'(lm_qubit), e.q);
        check(lm_bit == e.b, e.tag, "lm_bit", int'(lm_bit), int'(e.b));
      end
    end
  end

  function automatic void push_dn(input logic [3:0] op, input int qa, input int qb,
                                  input logic anc, input string tag);
    dn_exp_t e;
    e.op = op; e.qa = qa; e.qb = qb; e.anc = anc; e.tag = tag;
    dn_q.push_back(e);
  endfunction

  // model of the frame, applied at the accepting edge
  function automatic void model_op(input logic [3:0] op, input int qa, input int qb,
                                   input logic anc);
    bit t;
    if (anc) begin
      push_dn(op, qa, qb, anc, "R2");
      return;
    end
    case (op)
      OP_X: mx[qa] ^= 1'b1;
      OP_Z: mz[qa] ^= 1'b1;
      OP_Y: begin mx[qa] ^= 1'b1; mz[qa] ^= 1'b1; end
      OP_H: begin push_dn(op, qa, qb, 1'b0, "R4"); t = mx[qa]; mx[qa] = mz[qa]; mz[qa] = t; end
      OP_S: begin push_dn(op, qa, qb, 1'b0, "R5"); mz[qa] ^= mx[qa]; end
      OP_CX: begin
        push_dn(op, qa, qb, 1'b0, "R6");
        mx[qa] ^= mx[qb];
        mz[qb] ^= mz[qa];
      end
      OP_T, OP_TDG: begin
        if (mx[qa] || mz[qa])
          push_dn((mx[qa] && mz[qa]) ? OP_Y : (mx[qa] ? OP_X : OP_Z), qa, 0, 1'b0, "R7");
        mx[qa] = 1'b0;
        mz[qa] = 1'b0;
        push_dn(op, qa, qb, 1'b0, "R7");
      end
      OP_MZ:   push_dn(op, qa, qb, 1'b0, "R9");
      default: push_dn(op, qa, qb, 1'b0, "R12");
    endcase
  endfunction

  function automatic void model_res(input int q, input logic b, input string tag);
    lm_exp_t e;
    e.q = q; e.b = b ^ mx[q]; e.tag = tag;
    lm_q.push_back(e);
    mx[q] = 1'b0;
    mz[q] = 1'b0;
  endfunction

  task automatic send_op(input logic [3:0] op, input int qa, input int qb, input logic anc);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_qa = QW'(qa); in_qb = QW'(qb); in_anc = anc;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    model_op(op, qa, qb, anc);
    #1 in_valid = 1'b0;
  endtask

  task automatic send_res(input int q, input logic b);
    @(negedge clk);
    mr_valid = 1'b1; mr_qubit = QW'(q); mr_bit = b;
    #1;
    while (!mr_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    model_res(q, b, "R9");
    #1 mr_valid = 1'b0;
  endtask

  // R10: result and X on the same qubit in one cycle
  task automatic collide(input int q, input logic b);
    @(negedge clk);
    in_valid = 1'b1; in_op = OP_X; in_qa = QW'(q); in_qb = '0; in_anc = 1'b0;
    mr_valid = 1'b1; mr_qubit = QW'(q); mr_bit = b;
    #1;
    while (!(in_ready && mr_ready)) begin @(negedge clk); #1; end
    @(posedge clk);
    model_res(q, b, "R10");
    mx[q] ^= 1'b1;
    #1;
    in_valid = 1'b0;
    mr_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (dn_q.size() == 0 && lm_q.size() == 0 && !dn_valid && !lm_valid) break;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_op = '0; in_qa = '0; in_qb = '0; in_anc = 1'b0;
    mr_valid = 1'b0; mr_qubit = '0; mr_bit = 1'b0;
    dn_ready = 1'b1; lm_ready = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1: reset state
    check(dn_valid == 1'b0, "R1", "dn_valid", int'(dn_valid), 0);
    check(lm_valid == 1'b0, "R1", "lm_valid", int'(lm_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready", int'(in_ready), 1);
    check(mr_ready == 1'b1, "R1", "mr_ready", int'(mr_ready), 1);
    // R1: zero records leave results as they are
    send_res(5, 1'b1);
    send_res(6, 1'b0);

    // R3 and R9: absorbed X flips a later result, then record is gone
    send_op(OP_X, 1, 0, 1'b0);
    send_op(OP_MZ, 1, 0, 1'b0);
    send_res(1, 1'b0);
    send_res(1, 1'b0);

    // R7: Z pending gives Z correction, second T gives none
    send_op(OP_Z, 2, 0, 1'b0);
    send_op(OP_T, 2, 0, 1'b0);
    send_op(OP_T, 2, 0, 1'b0);
    // R3/R7: Y pending gives Y correction
    send_op(OP_Y, 3, 0, 1'b0);
    send_op(OP_TDG, 3, 0, 1'b0);

    // R4: H moves x into z
    send_op(OP_X, 4, 0, 1'b0);
    send_op(OP_H, 4, 0, 1'b0);
    send_op(OP_T, 4, 0, 1'b0);
    // R4 and R9: z alone leaves a result untouched
    send_op(OP_Z, 4, 0, 1'b0);
    send_res(4, 1'b1);
    send_op(OP_X, 4, 0, 1'b0);
    send_op(OP_H, 4, 0, 1'b0);
    send_op(OP_H, 4, 0, 1'b0);
    send_res(4, 1'b0);

    // R5: S copies x into z
    send_op(OP_X, 5, 0, 1'b0);
    send_op(OP_S, 5, 0, 1'b0);
    send_op(OP_T, 5, 0, 1'b0);

    // R6: CNOT rules, target 7, control 6
    send_op(OP_X, 6, 0, 1'b0);
    send_op(OP_CX, 7, 6, 1'b0);
    send_res(7, 1'b0);
    send_op(OP_Z, 7, 0, 1'b0);
    send_op(OP_CX, 7, 6, 1'b0);
    send_op(OP_T, 6, 0, 1'b0);
    send_op(OP_T, 7, 0, 1'b0);

    // R2: ancilla ops pass and touch no record
    send_op(OP_X, 8, 0, 1'b1);
    send_op(OP_T, 8, 0, 1'b0);
    send_op(OP_X, 9, 0, 1'b0);
    send_op(OP_T, 9, 3, 1'b1);
    send_op(OP_MZ, 9, 0, 1'b1);
    send_op(OP_T, 9, 0, 1'b0);

    // R12: unlisted opcode forwarded, record kept
    send_op(OP_X, 10, 0, 1'b0);
    send_op(4'd12, 10, 2, 1'b0);
    send_op(OP_T, 10, 0, 1'b0);
    drain();

    // R8: input blocked while correction waits
    send_op(OP_X, 11, 0, 1'b0);
    dn_hold = 1'b1;
    send_op(OP_T, 11, 0, 1'b0);
    @(negedge clk);
    #1;
    check(in_ready == 1'b0, "R8", "in_ready during correction", int'(in_ready), 0);
    check(dn_valid == 1'b1 && dn_op == OP_X, "R8", "correction held",
          int'(dn_op), int'(OP_X));
    @(negedge clk);
    #1;
    check(in_ready == 1'b0, "R8", "in_ready still low", int'(in_ready), 0);
    dn_hold = 1'b0;
    drain();

    // R10: result and gate on one qubit in one cycle
    send_op(OP_X, 12, 0, 1'b0);
    collide(12, 1'b0);
    send_res(12, 1'b0);
    drain();

    // R11: random stalls on both outputs with mixed traffic
    stall_en = 1'b1;
    for (int i = 0; i < 64; i++) begin
      int q;
      q = i % NQ;
      case (i % 8)
        0: send_op(OP_X, q, 0, 1'b0);
        1: send_op(OP_H, q, 0, 1'b0);
        2: send_op(OP_CX, q, (q + 1) % NQ, 1'b0);
        3: send_op(OP_S, q, 0, 1'b0);
        4: send_op(OP_T, q, 0, 1'b0);
        5: begin send_op(OP_MZ, q, 0, 1'b0); send_res(q, logic'(i[1])); end
        6: send_op(OP_Z, q, 0, 1'b1);
        default: send_op(OP_Y, q, 0, 1'b0);
      endcase
    end
    stall_en = 1'b0;
    drain();
    // R11: nothing lost
    check(dn_q.size() == 0, "R11", "pending downstream ops", dn_q.size(), 0);
    check(lm_q.size() == 0, "R11", "pending results", lm_q.size(), 0);
    finish_run();
  end

endmodule